// File: doc/BRIEF.md
# I2C Bus Unstick Sequencer

This block frees a two-wire I2C bus that a slave device is holding in a stuck state. It sits between the normal master engine and the open-drain pad drivers. On a trigger it takes over both drive enables. It keeps the data line released and clocks the clock line until the data line is seen high or the pulse budget is used up. It then places a START and a STOP on the bus so that every attached device returns to idle. When the sequence ends it raises a one-cycle done pulse. A status bit tells whether both lines were high at the close. A slave that holds the clock line low during a released phase cannot hang the sequencer: the number of low cycles it waits is bounded, and when the bound is reached the sequence ends with a failed status.

There are three sources that start a recovery. The first is an explicit request. The second is a bus-error pulse. The third is a run of failed transactions of programmable length, with no success in between. A watchdog in the same block counts cycles since the last successful transaction or the last finished recovery. When the count reaches a programmed limit, the watchdog pulses a request to reset the peripheral. All timing values are run-time inputs: the half-period length, the stretch bound, the failure threshold and the watchdog period. Drive enables are active high: 1 pulls the line low and 0 releases it.

Top module: `i2c_unstick`

## Requirements
- R1: While no recovery is running, `scl_oe` and `sda_oe` equal `mst_scl_oe` and `mst_sda_oe` in the same cycle.
- R2: A `rec_req` or `bus_err` pulse sampled on an idle edge makes `rec_busy` high after that edge. A trigger sampled while busy is dropped and does not restart or lengthen the sequence.
- R3: With `fail_max` = N > 0, the N-th `xact_fail` pulse with no `xact_ok` in between starts a recovery exactly like `rec_req`. An `xact_ok` pulse, or any trigger, restarts that count. `fail_max` = 0 disables this source.
- R4: Each recovery pulse drives SCL low (`scl_oe`=1) for `half_cnt` cycles, then releases it for `half_cnt` cycles in which SCL is sampled high. `sda_oe` stays 0 throughout. If SDA stays low, exactly 9 pulses are produced.
- R5: SDA is sampled at the last cycle of each released half. If it is high there, pulsing stops and the START/STOP phase follows at once, so at least 1 pulse is always produced.
- R6: The closing phase consists of four parts, each `half_cnt` cycles long, in this order: SCL released with SDA low (START); both low; SCL released with SDA low; both released (STOP).
- R7: In a released-SCL half, only cycles with SCL sampled high advance the half timer. The `stretch_lim`-th low cycle in that half ends the sequence at once with `rec_ok`=0.
- R8: `rec_done` is a one-cycle pulse in the first cycle after `rec_busy` falls. `rec_ok` is 1 only if SCL and SDA were both sampled high on the last STOP cycle. It holds until the next recovery starts.
- R9: `per_rst_req` pulses for one cycle after `wdog_lim` consecutive edges without `xact_ok` or `rec_done`. The count then starts over. Either clear input restarts the count, and `wdog_lim` = 0 disables the watchdog.
- R10: While `rec_busy` is high, the master enables have no effect on `scl_oe` and `sda_oe`.
- R11: After reset, `rec_busy`, `rec_done`, `rec_ok` and `per_rst_req` are 0, and the outputs pass the master enables through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_scl_oe | input | 1 | Master engine clock pull-down enable |
| mst_sda_oe | input | 1 | Master engine data pull-down enable |
| scl_in | input | 1 | Synchronized clock line level |
| sda_in | input | 1 | Synchronized data line level |
| rec_req | input | 1 | Explicit recovery request pulse |
| bus_err | input | 1 | Bus error pulse, starts recovery |
| xact_ok | input | 1 | Successful transaction pulse |
| xact_fail | input | 1 | Failed transaction pulse |
| half_cnt | input | 16 | Cycles per half of a recovery pulse |
| stretch_lim | input | 16 | Maximum low cycles waited in a released half |
| fail_max | input | 4 | Failures that trigger recovery, 0 = off |
| wdog_lim | input | 24 | Watchdog period in cycles, 0 = off |
| scl_oe | output | 1 | Clock pull-down enable to the pad |
| sda_oe | output | 1 | Data pull-down enable to the pad |
| rec_busy | output | 1 | Recovery in progress |
| rec_done | output | 1 | Recovery finished pulse |
| rec_ok | output | 1 | Both lines high at end of last recovery |
| per_rst_req | output | 1 | Peripheral reset request pulse |

## Verification
The bench connects the block to a modelled wired-AND bus with a misbehaving slave. Recoveries are run under several slave conditions. With the data line held low for good, the run must give the full nine pulses and a failed status. With a slave that lets go after four clock falls, the run must stop after four pulses. With a clean bus, a single pulse is expected. A slave that stretches one high half for five cycles must be tolerated, while one that holds the clock low forever must end in the bounded failure. Interleaved failure and success pulses show the failure threshold from the other trigger sources. Quiet stretches with different watchdog limits show whether the reset requests are spaced correctly, whether an early clear restarts the count, and whether a zero limit suppresses them.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_STA,
        ST_SLO,
        ST_SHI,
        ST_STP
    } seq_st_e;

    localparam int UNSTICK_PULSES = 9;

endpackage

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq
    import i2c_unstick_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NPULSE = UNSTICK_PULSES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [CNT_W-1:0] half_cnt,
    input  logic [CNT_W-1:0] stretch_lim,
    output logic             busy,
    output logic             scl_low,
    output logic             sda_low,
    output logic             done,
    output logic             ok
);

    localparam int PC_W = $clog2(NPULSE + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] tmr;
        logic [CNT_W-1:0] stall;
        logic [PC_W-1:0]  pc;
        logic             done;
        logic             ok;
    } seq_t;

    seq_t s_q, s_d;

    logic [CNT_W:0] tmr_inc, stall_inc;
    logic           half_end, stall_end, pc_last;

    assign tmr_inc   = {1'b0, s_q.tmr} + (CNT_W+1)'(1);
    assign stall_inc = {1'b0, s_q.stall} + (CNT_W+1)'(1);
    assign half_end  = tmr_inc >= {1'b0, half_cnt};
    assign stall_end = stall_inc >= {1'b0, stretch_lim};
    assign pc_last   = s_q.pc == PC_W'(NPULSE - 1);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (trig) begin
                    s_d.st  = ST_LO;
                    s_d.tmr = '0;
                    s_d.pc  = '0;
                    s_d.ok  = 1'b0;
                end
            end
            ST_LO, ST_STA, ST_SLO, ST_STP: begin
                if (half_end) begin
                    s_d.tmr   = '0;
                    s_d.stall = '0;
                    case (s_q.st)
                        ST_LO:   s_d.st = ST_HI;
                        ST_STA:  s_d.st = ST_SLO;
                        ST_SLO:  s_d.st = ST_SHI;
                        default: begin
                            s_d.st   = ST_IDLE;
                            s_d.done = 1'b1;
                            s_d.ok   = scl_in & sda_in;
                        end
                    endcase
                end else begin
                    s_d.tmr = tmr_inc[CNT_W-1:0];
                end
            end
            ST_HI, ST_SHI: begin
                if (!scl_in) begin
                    if (stall_end) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.ok   = 1'b0;
                    end else begin
                        s_d.stall = stall_inc[CNT_W-1:0];
                    end
                end else if (half_end) begin
                    s_d.tmr   = '0;
                    s_d.stall = '0;
                    if (s_q.st == ST_SHI) begin
                        s_d.st = ST_STP;
                    end else begin
                        s_d.pc = s_q.pc + PC_W'(1);
                        s_d.st = (pc_last || sda_in) ? ST_STA : ST_LO;
                    end
                end else begin
                    s_d.tmr = tmr_inc[CNT_W-1:0];
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.st != ST_IDLE;
    assign scl_low = (s_q.st == ST_LO) || (s_q.st == ST_SLO);
    assign sda_low = (s_q.st == ST_STA) || (s_q.st == ST_SLO) || (s_q.st == ST_SHI);
    assign done    = s_q.done;
    assign ok      = s_q.ok;

endmodule

// File: rtl/i2c_unstick_wdog.sv
module i2c_unstick_wdog #(
    parameter int FAIL_W = 4,
    parameter int WD_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_req,
    input  logic              bus_err,
    input  logic              xact_ok,
    input  logic              xact_fail,
    input  logic              rec_done,
    input  logic [FAIL_W-1:0] fail_max,
    input  logic [WD_W-1:0]   wdog_lim,
    output logic              trig,
    output logic              per_rst_req
);

    typedef struct packed {
        logic [FAIL_W-1:0] fails;
        logic [WD_W-1:0]   wd;
        logic              prst;
    } wd_t;

    wd_t w_q, w_d;

    logic [FAIL_W:0] fail_inc;
    logic [WD_W:0]   wd_inc;
    logic            fail_hit, clr, lim_hit;

    assign fail_inc = {1'b0, w_q.fails} + (FAIL_W+1)'(1);
    assign wd_inc   = {1'b0, w_q.wd} + (WD_W+1)'(1);
    assign fail_hit = xact_fail && (fail_max != '0) && (fail_inc >= {1'b0, fail_max});
    assign trig     = rec_req | bus_err | fail_hit;
    assign clr      = xact_ok | rec_done;
    assign lim_hit  = (wdog_lim != '0) && (wd_inc >= {1'b0, wdog_lim});

    always_comb begin
        w_d = w_q;
        if (xact_ok || trig) begin
            w_d.fails = '0;
        end else if (xact_fail && (w_q.fails != '1)) begin
            w_d.fails = fail_inc[FAIL_W-1:0];
        end
        if (clr) begin
            w_d.wd   = '0;
            w_d.prst = 1'b0;
        end else if (lim_hit) begin
            w_d.wd   = '0;
            w_d.prst = 1'b1;
        end else begin
            w_d.wd   = wd_inc[WD_W-1:0];
            w_d.prst = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign per_rst_req = w_q.prst;

endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick #(
    parameter int CNT_W  = 16,
    parameter int FAIL_W = 4,
    parameter int WD_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_scl_oe,
    input  logic              mst_sda_oe,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              rec_req,
    input  logic              bus_err,
    input  logic              xact_ok,
    input  logic              xact_fail,
    input  logic [CNT_W-1:0]  half_cnt,
    input  logic [CNT_W-1:0]  stretch_lim,
    input  logic [FAIL_W-1:0] fail_max,
    input  logic [WD_W-1:0]   wdog_lim,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              rec_busy,
    output logic              rec_done,
    output logic              rec_ok,
    output logic              per_rst_req
);

    logic trig, seq_scl_low, seq_sda_low;

    i2c_unstick_wdog #(
        .FAIL_W (FAIL_W),
        .WD_W   (WD_W)
    ) u_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .rec_req     (rec_req),
        .bus_err     (bus_err),
        .xact_ok     (xact_ok),
        .xact_fail   (xact_fail),
        .rec_done    (rec_done),
        .fail_max    (fail_max),
        .wdog_lim    (wdog_lim),
        .trig        (trig),
        .per_rst_req (per_rst_req)
    );

    i2c_unstick_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (trig),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .half_cnt    (half_cnt),
        .stretch_lim (stretch_lim),
        .busy        (rec_busy),
        .scl_low     (seq_scl_low),
        .sda_low     (seq_sda_low),
        .done        (rec_done),
        .ok          (rec_ok)
    );

    // Pad enable selection: sequencer owns the bus while busy
    assign scl_oe = rec_busy ? seq_scl_low : mst_scl_oe;
    assign sda_oe = rec_busy ? seq_sda_low : mst_sda_oe;

endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             scl_in,
    input logic             sda_in,
    input logic             rec_busy,
    input logic             rec_done,
    input logic             rec_ok,
    input logic [CNT_W-1:0] half_cnt,
    input logic [CNT_W-1:0] stretch_lim
);

    logic [CNT_W+1:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (rec_busy && !scl_oe && !scl_in) begin
            low_run <= low_run + (CNT_W+2)'(1);
        end else begin
            low_run <= '0;
        end
    end

    p_first_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_busy) |-> (scl_oe && !sda_oe));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> !rec_done);

    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> (!rec_busy && $past(rec_busy)));

    p_ok_lines_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_done && rec_ok) |-> ($past(scl_in) && $past(sda_in)));

    p_stretch_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= ({2'b00, stretch_lim} + {2'b00, half_cnt}));

endmodule

bind i2c_unstick i2c_unstick_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .scl_in      (scl_in),
    .sda_in      (sda_in),
    .rec_busy    (rec_busy),
    .rec_done    (rec_done),
    .rec_ok      (rec_ok),
    .half_cnt    (half_cnt),
    .stretch_lim (stretch_lim)
);

// File: tb/test_i2c_unstick.sv
module test_i2c_unstick;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mst_scl_oe = 1'b0, mst_sda_oe = 1'b0;
    logic        rec_req = 1'b0, bus_err = 1'b0, xact_ok = 1'b0, xact_fail = 1'b0;
    logic [15:0] half_cnt = 16'd3, stretch_lim = 16'd20;
    logic [3:0]  fail_max = 4'd3;
    logic [23:0] wdog_lim = 24'd1000;
    logic        scl_oe, sda_oe, rec_busy, rec_done, rec_ok, per_rst_req;
    logic        scl_line, sda_line;

    // bus slave model controls
    logic        arm = 1'b0, scl_stuck = 1'b0;
    int          sda_cfg = 0, str_cfg = 0;
    int          sda_cnt = 0, str_once = 0, hold = 0, pulses = 0, prst_seen = 0;
    logic        prev_oe = 1'b0;

    int compared = 0, mismatched = 0;

    always #2.5ns clk = ~clk;

    assign scl_line = !(scl_oe || (hold != 0) || scl_stuck);
    assign sda_line = !(sda_oe || (sda_cnt != 0));

    i2c_unstick i_i2c_unstick (
        .clk(clk), .rst_n(rst_n), .mst_scl_oe(mst_scl_oe), .mst_sda_oe(mst_sda_oe),
        .scl_in(scl_line), .sda_in(sda_line), .rec_req(rec_req), .bus_err(bus_err),
        .xact_ok(xact_ok), .xact_fail(xact_fail), .half_cnt(half_cnt),
        .stretch_lim(stretch_lim), .fail_max(fail_max), .wdog_lim(wdog_lim),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rec_busy(rec_busy), .rec_done(rec_done),
        .rec_ok(rec_ok), .per_rst_req(per_rst_req)
    );

    // Slave behaviour: holds SDA for a number of clock falls, may stretch once
    always @(negedge clk) begin
        if (arm) begin
            sda_cnt  <= sda_cfg;
            str_once <= str_cfg;
            hold     <= 0;
            pulses   <= 0;
        end else begin
            if (rec_busy && scl_oe && !prev_oe && sda_cnt > 0) sda_cnt <= sda_cnt - 1;
            if (rec_busy && scl_oe && !prev_oe && !sda_oe) pulses <= pulses + 1;
            if (rec_busy && !scl_oe && prev_oe && str_once > 0) begin
                hold     <= str_once;
                str_once <= 0;
            end else if (hold > 0) begin
                hold <= hold - 1;
            end
        end
        if (per_rst_req) prst_seen <= prst_seen + 1;
        prev_oe <= scl_oe;
    end

    // Behavioural reference model, phase codes: 0 idle,1 low,2 high,3 start,4 both low,5 high w/ sda low,6 stop
    int   m_ph = 0, m_t = 0, m_st = 0, m_pc = 0, m_fail = 0, m_wd = 0;
    logic m_done = 0, m_ok = 0, m_prst = 0;

    always @(posedge clk) begin
        logic trig, nd;
        if (!rst_n) begin
            m_ph = 0; m_t = 0; m_st = 0; m_pc = 0; m_fail = 0; m_wd = 0;
            m_done = 0; m_ok = 0; m_prst = 0;
        end else begin
            trig = rec_req || bus_err ||
                   (xact_fail && fail_max != 0 && (m_fail + 1) >= int'(fail_max));
            if (xact_ok || m_done) begin
                m_wd = 0; m_prst = 0;
            end else if (wdog_lim != 0 && (m_wd + 1) >= int'(wdog_lim)) begin
                m_wd = 0; m_prst = 1;
            end else begin
                m_wd = m_wd + 1; m_prst = 0;
            end
            if (xact_ok || trig) m_fail = 0;
            else if (xact_fail && m_fail < 15) m_fail = m_fail + 1;
            nd = 0;
            case (m_ph)
                0: if (trig) begin m_ph = 1; m_t = 0; m_pc = 0; m_ok = 0; end
                1, 3, 4, 6: begin
                    if (m_t + 1 >= int'(half_cnt)) begin
                        m_t = 0; m_st = 0;
                        if (m_ph == 6) begin m_ph = 0; nd = 1; m_ok = scl_line && sda_line; end
                        else if (m_ph == 1) m_ph = 2;
                        else m_ph = m_ph + 1;
                    end else m_t = m_t + 1;
                end
                default: begin
                    if (!scl_line) begin
                        if (m_st + 1 >= int'(stretch_lim)) begin m_ph = 0; nd = 1; m_ok = 0; end
                        else m_st = m_st + 1;
                    end else if (m_t + 1 >= int'(half_cnt)) begin
                        m_t = 0; m_st = 0;
                        if (m_ph == 5) m_ph = 6;
                        else begin
                            m_pc = m_pc + 1;
                            m_ph = (m_pc == 9 || sda_line) ? 3 : 1;
                        end
                    end else m_t = m_t + 1;
                end
            endcase
            m_done = nd;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle comparison against the model, away from the edge
    always @(posedge clk) begin
        #1ns;
        if (rst_n) begin
            string tg;
            logic  e_scl, e_sda;
            tg = (m_ph == 0) ? "R1" : (m_ph <= 2) ? "R4" : "R6";
            e_scl = (m_ph == 0) ? mst_scl_oe : (m_ph == 1 || m_ph == 4);
            e_sda = (m_ph == 0) ? mst_sda_oe : (m_ph >= 3 && m_ph <= 5);
            chk({tg, " scl_oe"}, int'(scl_oe), int'(e_scl));
            chk({tg, " sda_oe"}, int'(sda_oe), int'(e_sda));
            chk("R2 rec_busy", int'(rec_busy), int'(m_ph != 0));
            chk("R8 rec_done", int'(rec_done), int'(m_done));
            chk("R8 rec_ok", int'(rec_ok), int'(m_ok));
            chk("R9 per_rst_req", int'(per_rst_req), int'(m_prst));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup_slave(input int sda_hold, input int stretch);
        @(negedge clk);
        sda_cfg = sda_hold; str_cfg = stretch; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (n < 3000) begin
            @(posedge clk); #1ns;
            if (rec_done) break;
            n++;
        end
        chk({tag, " done seen"}, int'(n < 3000), 1);
    endtask

    initial begin
        #(200000 * 5ns);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        @(posedge clk); #1ns;
        // R11 reset state
        chk("R11 busy", int'(rec_busy), 0);
        chk("R11 done", int'(rec_done), 0);
        chk("R11 ok", int'(rec_ok), 0);
        chk("R11 prst", int'(per_rst_req), 0);

        // R1 passthrough patterns
        @(negedge clk); mst_scl_oe = 1; mst_sda_oe = 0;
        #1ns; chk("R1 scl pass", int'(scl_oe), 1); chk("R1 sda pass", int'(sda_oe), 0);
        @(negedge clk); mst_scl_oe = 0; mst_sda_oe = 1;
        #1ns; chk("R1 scl pass", int'(scl_oe), 0); chk("R1 sda pass", int'(sda_oe), 1);
        @(negedge clk); mst_sda_oe = 0;

        // R4 SDA stuck forever: nine pulses, failed status; R10 master ignored; R2 trigger while busy dropped
        setup_slave(1000, 0);
        @(negedge clk); rec_req = 1;
        @(negedge clk); rec_req = 0; mst_scl_oe = 1; mst_sda_oe = 1;
        cyc(10);
        rec_req = 1;
        @(negedge clk); rec_req = 0; mst_scl_oe = 0;
        wait_done("R4");
        chk("R4 nine pulses", pulses, 9);
        chk("R8 ok low with sda stuck", int'(rec_ok), 0);
        @(negedge clk); mst_sda_oe = 0;

        // R5 slave releases after four falls: early exit
        setup_slave(4, 0);
        @(negedge clk); rec_req = 1;
        @(negedge clk); rec_req = 0;
        wait_done("R5");
        chk("R5 early exit pulses", pulses, 4);
        chk("R8 ok after release", int'(rec_ok), 1);

        // R2 bus error on a clean bus: single pulse
        setup_slave(0, 0);
        @(negedge clk); bus_err = 1;
        @(negedge clk); bus_err = 0;
        wait_done("R2");
        chk("R5 single pulse clean bus", pulses, 1);
        chk("R6 ok clean", int'(rec_ok), 1);

        // R7 bounded stretch tolerated
        setup_slave(0, 5);
        @(negedge clk); rec_req = 1;
        @(negedge clk); rec_req = 0;
        wait_done("R7");
        chk("R7 stretch tolerated ok", int'(rec_ok), 1);

        // R7 SCL stuck low: bounded failure
        setup_slave(0, 0);
        @(negedge clk); scl_stuck = 1; rec_req = 1;
        @(negedge clk); rec_req = 0;
        wait_done("R7");
        chk("R7 stuck scl fails", int'(rec_ok), 0);
        chk("R7 stuck scl one pulse", pulses, 1);
        @(negedge clk); scl_stuck = 0;
        cyc(2);

        // R3 failure threshold
        setup_slave(0, 0);
        @(negedge clk); xact_fail = 1; @(negedge clk); xact_fail = 0;
        @(negedge clk); xact_fail = 1; @(negedge clk); xact_fail = 0;
        @(negedge clk); xact_ok = 1;   @(negedge clk); xact_ok = 0;
        @(negedge clk); xact_fail = 1; @(negedge clk); xact_fail = 0;
        @(negedge clk); xact_fail = 1; @(negedge clk); xact_fail = 0;
        #1ns; chk("R3 no trigger before threshold", int'(rec_busy), 0);
        @(negedge clk); xact_fail = 1;
        @(posedge clk); #1ns;
        chk("R3 third failure triggers", int'(rec_busy), 1);
        @(negedge clk); xact_fail = 0;
        wait_done("R3");

        // R9 watchdog spacing, clear, disable
        @(negedge clk); wdog_lim = 24'd40; xact_ok = 1;
        @(negedge clk); xact_ok = 0; prst_seen = 0;
        cyc(100);
        chk("R9 two requests in 100 cycles", prst_seen, 2);
        @(negedge clk); xact_ok = 1;
        @(negedge clk); xact_ok = 0; prst_seen = 0;
        cyc(30);
        xact_ok = 1; @(negedge clk); xact_ok = 0;
        cyc(30);
        chk("R9 clear restarts count", prst_seen, 0);
        wdog_lim = 24'd0; prst_seen = 0;
        cyc(100);
        chk("R9 zero limit disables", prst_seen, 0);

        cyc(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule